// File: doc/BRIEF.md
# Fewest-in-flight fetch thread selector

In a front end that runs several hardware threads at once, this block decides each cycle which thread gets the fetch slot. It keeps a running count of instructions each thread has in flight. It then grants fetch to the eligible thread with the smallest count. This favours threads that drain quickly and keeps any single thread from flooding the shared instruction queue.

A count rises by the fetch width when a grant is accepted. It falls by the retire and squash amounts reported for that thread, and both may arrive in the same cycle. A thread is eligible when it is active and ready. When two or more threads are active, it must also hold fewer than its fair share of queue entries. With only one thread active, that thread may fill the whole queue.

Ties on count go to a rotating priority pointer. If the fetch unit does not accept a grant, the same thread stays selected in the next cycle.

Top module: `icnt_fetch_sel`

## Requirements
- R1: After reset all counts are zero and the priority pointer is at thread 0. When all threads are eligible, the first grant therefore goes to thread 0.
- R2: Only a thread whose `thr_active` and `thr_ready` bits are both 1 can be granted. When no thread is eligible, `fetch_valid` is 0.
- R3: The granted thread has the smallest in-flight count among the eligible threads.
- R4: Ties on count are resolved in thread order, starting at the priority pointer. After an accepted fetch, the pointer moves to the winner plus one, modulo NUM_THREADS.
- R5: A fetch is accepted when `fetch_valid` and `fetch_ready` are both 1. An accepted fetch raises the granted thread's count by FETCH_WIDTH (default 4).
- R6: The per-thread retire and squash amounts are subtracted in the same cycle. The result is clamped at zero and at MAX_INFLIGHT.
- R7: When two or more threads are active, a thread is ineligible if its queue occupancy is at least QUEUE_DEPTH/NUM_THREADS (16 at the defaults).
- R8: When exactly one thread is active, occupancy does not limit it. Any occupancy up to QUEUE_DEPTH leaves it eligible.
- R9: When `fetch_valid` is 1 and `fetch_ready` is 0, no count rises and the pointer does not move. The same thread is selected in the next cycle as long as it is still eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | NUM_THREADS | Thread holds a running context |
| thr_ready | input | NUM_THREADS | Thread is able to fetch this cycle |
| fetch_ready | input | 1 | Fetch unit accepts the grant |
| retire_amt | input | NUM_THREADS*AMT_W | Instructions retired per thread, thread 0 in the low bits |
| squash_amt | input | NUM_THREADS*AMT_W | Instructions squashed per thread, thread 0 in the low bits |
| queue_occ | input | NUM_THREADS*OCC_W | Queue entries held per thread, thread 0 in the low bits |
| fetch_valid | output | 1 | A thread is granted this cycle |
| fetch_tid | output | TID_W | Granted thread |

## Verification
Errors in the counts do not show on any port directly. They show up as a wrong choice of thread once two eligible threads differ, or are tied, in their counts. A count that is off by one fetch or fails to clamp at zero therefore shows on the first later cycle where the comparison between threads decides the grant. A stuck pointer or a lost hold shows on the very next grant. The bench uses that next-grant comparison as its observation point, replaying every cycle against a model built from the requirements.

// File: rtl/icnt_fetch_pkg.sv
package icnt_fetch_pkg;
   function automatic int unsigned width_of(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/icnt_inflight_ctr.sv
module icnt_inflight_ctr #(
   parameter int unsigned CNT_W       = 7,
   parameter int unsigned AMT_W       = 3,
   parameter int unsigned FETCH_WIDTH = 4,
   parameter int unsigned MAX_INFLIGHT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic [AMT_W-1:0] ret,
   input  logic [AMT_W-1:0] sq,
   output logic [CNT_W-1:0] cnt
);
   localparam int unsigned SW = ((CNT_W > AMT_W) ? CNT_W : AMT_W) + 2;

   logic [SW-1:0] grown;
   logic [SW-1:0] shrink;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      grown  = SW'(cnt) + (inc ? SW'(FETCH_WIDTH) : '0);
      shrink = SW'(ret) + SW'(sq);
      if (grown <= shrink)
         nxt = '0;
      else if ((grown - shrink) > SW'(MAX_INFLIGHT))
         nxt = CNT_W'(MAX_INFLIGHT);
      else
         nxt = CNT_W'(grown - shrink);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end
endmodule

// File: rtl/icnt_pick.sv
module icnt_pick #(
   parameter int unsigned NUM_THREADS = 2,
   parameter int unsigned CNT_W       = 7,
   parameter int unsigned TID_W       = 1
) (
   input  logic [NUM_THREADS-1:0]       elig,
   input  logic [NUM_THREADS*CNT_W-1:0] cnts,
   input  logic [TID_W-1:0]             ptr,
   input  logic                         hold_vld,
   input  logic [TID_W-1:0]             hold_tid,
   output logic                         pick_vld,
   output logic [TID_W-1:0]             pick_tid
);
   logic [CNT_W-1:0] best;
   int unsigned idx;

   always_comb begin
      pick_vld = 1'b0;
      pick_tid = '0;
      best     = '0;
      idx      = 0;
      if (hold_vld && elig[hold_tid]) begin
         pick_vld = 1'b1;
         pick_tid = hold_tid;
      end else begin
         for (int unsigned i = 0; i < NUM_THREADS; i++) begin
            idx = int'(ptr) + i;
            if (idx >= NUM_THREADS) idx = idx - NUM_THREADS;
            if (elig[idx] && (!pick_vld || (cnts[idx*CNT_W +: CNT_W] < best))) begin
               pick_vld = 1'b1;
               pick_tid = TID_W'(idx);
               best     = cnts[idx*CNT_W +: CNT_W];
            end
         end
      end
   end
endmodule

// File: rtl/icnt_fetch_sel.sv
module icnt_fetch_sel
   import icnt_fetch_pkg::*;
#(
   parameter int unsigned NUM_THREADS  = 2,
   parameter int unsigned QUEUE_DEPTH  = 32,
   parameter int unsigned FETCH_WIDTH  = 4,
   parameter int unsigned AMT_W        = 3,
   parameter int unsigned MAX_INFLIGHT = 64,
   parameter int unsigned OCC_W        = $clog2(QUEUE_DEPTH + 1),
   parameter int unsigned TID_W        = width_of(NUM_THREADS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_THREADS-1:0]       thr_active,
   input  logic [NUM_THREADS-1:0]       thr_ready,
   input  logic                         fetch_ready,
   input  logic [NUM_THREADS*AMT_W-1:0] retire_amt,
   input  logic [NUM_THREADS*AMT_W-1:0] squash_amt,
   input  logic [NUM_THREADS*OCC_W-1:0] queue_occ,
   output logic                         fetch_valid,
   output logic [TID_W-1:0]             fetch_tid
);
   localparam int unsigned CNT_W   = $clog2(MAX_INFLIGHT + 1);
   localparam int unsigned PER_CAP = QUEUE_DEPTH / NUM_THREADS;

   if (NUM_THREADS < 1) begin : g_bad_threads
      $error("NUM_THREADS must be at least 1");
   end
   if (FETCH_WIDTH > MAX_INFLIGHT) begin : g_bad_fw
      $error("FETCH_WIDTH exceeds MAX_INFLIGHT");
   end
   if (PER_CAP < 1) begin : g_bad_cap
      $error("QUEUE_DEPTH too small for NUM_THREADS");
   end

   logic [NUM_THREADS-1:0]       elig;
   logic [NUM_THREADS*CNT_W-1:0] cnts;
   logic                         multi;
   logic                         accept;
   logic [TID_W-1:0]             ptr;
   logic                         hold_vld;
   logic [TID_W-1:0]             hold_tid;

   assign multi  = $countones(thr_active) > 1;
   assign accept = fetch_valid && fetch_ready;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic over_cap;
      if (NUM_THREADS > 1) begin : g_capped
         assign over_cap = multi && (queue_occ[t*OCC_W +: OCC_W] >= OCC_W'(PER_CAP));
      end else begin : g_solo
         assign over_cap = 1'b0;
      end
      assign elig[t] = thr_active[t] && thr_ready[t] && !over_cap;

      icnt_inflight_ctr #(
         .CNT_W(CNT_W), .AMT_W(AMT_W),
         .FETCH_WIDTH(FETCH_WIDTH), .MAX_INFLIGHT(MAX_INFLIGHT)
      ) u_ctr (
         .clk(clk), .rst_n(rst_n),
         .inc(accept && (fetch_tid == TID_W'(t))),
         .ret(retire_amt[t*AMT_W +: AMT_W]),
         .sq(squash_amt[t*AMT_W +: AMT_W]),
         .cnt(cnts[t*CNT_W +: CNT_W])
      );
   end

   icnt_pick #(
      .NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)
   ) u_pick (
      .elig(elig), .cnts(cnts), .ptr(ptr),
      .hold_vld(hold_vld), .hold_tid(hold_tid),
      .pick_vld(fetch_valid), .pick_tid(fetch_tid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr      <= '0;
         hold_vld <= 1'b0;
         hold_tid <= '0;
      end else begin
         hold_vld <= fetch_valid && !fetch_ready;
         hold_tid <= fetch_tid;
         if (accept) begin
            if (fetch_tid == TID_W'(NUM_THREADS - 1)) ptr <= '0;
            else                                       ptr <= fetch_tid + TID_W'(1);
         end
      end
   end
endmodule

// File: rtl/icnt_fetch_sel_chk.sv
module icnt_fetch_sel_chk #(
   parameter int unsigned NUM_THREADS = 2,
   parameter int unsigned QUEUE_DEPTH = 32,
   parameter int unsigned OCC_W       = 6,
   parameter int unsigned TID_W       = 1,
   parameter int unsigned CNT_W       = 7
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_THREADS-1:0]       thr_active,
   input logic [NUM_THREADS-1:0]       thr_ready,
   input logic                         fetch_ready,
   input logic [NUM_THREADS*OCC_W-1:0] queue_occ,
   input logic [NUM_THREADS-1:0]       elig,
   input logic [NUM_THREADS*CNT_W-1:0] cnts,
   input logic                         fetch_valid,
   input logic [TID_W-1:0]             fetch_tid
);
   localparam int unsigned PER_CAP = QUEUE_DEPTH / NUM_THREADS;

   // R2
   grant_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (thr_active[fetch_tid] && thr_ready[fetch_tid]));

   // R2
   idle_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (elig == '0) |-> !fetch_valid);

   // R7
   cap_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && ($countones(thr_active) > 1)) |->
         (queue_occ[fetch_tid*OCC_W +: OCC_W] < OCC_W'(PER_CAP)));

   // R9
   hold_same_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !fetch_ready) |=>
         (!elig[$past(fetch_tid)] || (fetch_valid && fetch_tid == $past(fetch_tid))));

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_min
      // R3
      min_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fetch_valid && elig[t] && !$past(fetch_valid && !fetch_ready)) |->
            (cnts[fetch_tid*CNT_W +: CNT_W] <= cnts[t*CNT_W +: CNT_W]));
   end
endmodule

bind icnt_fetch_sel icnt_fetch_sel_chk #(
   .NUM_THREADS(NUM_THREADS), .QUEUE_DEPTH(QUEUE_DEPTH),
   .OCC_W(OCC_W), .TID_W(TID_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .thr_ready(thr_ready),
   .fetch_ready(fetch_ready), .queue_occ(queue_occ), .elig(elig), .cnts(cnts),
   .fetch_valid(fetch_valid), .fetch_tid(fetch_tid)
);

// File: tb/icnt_fetch_sel_tb.sv
`timescale 1ns/1ps
module icnt_fetch_sel_tb;
   localparam int N = 2, AW = 3, OW = 6, FW = 4, MAXC = 64, CAP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  thr_active = '0, thr_ready = '0;
   logic          fetch_ready = 1'b0;
   logic [N*AW-1:0] retire_amt = '0, squash_amt = '0;
   logic [N*OW-1:0] queue_occ = '0;
   logic          fetch_valid;
   logic [0:0]    fetch_tid;

   always #4 clk = ~clk;

   icnt_fetch_sel u_dut (
      .clk(clk), .rst_n(rst_n), .thr_active(thr_active), .thr_ready(thr_ready),
      .fetch_ready(fetch_ready), .retire_amt(retire_amt), .squash_amt(squash_amt),
      .queue_occ(queue_occ), .fetch_valid(fetch_valid), .fetch_tid(fetch_tid)
   );

   typedef struct { bit v; int tid; string req; } exp_t;
   exp_t sb[$];
   event chk_ev;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   int mcnt[N];
   int mptr = 0;
   bit mhold = 1'b0;
   int mhtid = 0;

   // Monitor: pops one expected item per check event and compares
   initial begin
      forever begin
         @(chk_ev);
         if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (fetch_valid !== e.v || (e.v && int'(fetch_tid) != e.tid)) begin
               n_fail++;
               $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                        e.req, fetch_valid, fetch_tid, e.v, e.tid);
            end
         end
      end
   end

   // Driver: drive one cycle, predict the grant, then advance the model
   task automatic step(input bit [1:0] act, input bit [1:0] rdy, input bit frdy,
                       input int r0, input int r1, input int s0, input int s1,
                       input int o0, input int o1, input string req);
      bit el[N];
      bit ev;
      int tid, best, idx, nv;
      bit multi;
      @(negedge clk);
      thr_active  = act;
      thr_ready   = rdy;
      fetch_ready = frdy;
      retire_amt  = {AW'(r1), AW'(r0)};
      squash_amt  = {AW'(s1), AW'(s0)};
      queue_occ   = {OW'(o1), OW'(o0)};
      multi = act[0] && act[1];
      el[0] = act[0] && rdy[0] && !(multi && o0 >= CAP);
      el[1] = act[1] && rdy[1] && !(multi && o1 >= CAP);
      ev = 1'b0; tid = 0; best = 0;
      if (mhold && el[mhtid]) begin
         ev = 1'b1; tid = mhtid;
      end else begin
         for (int i = 0; i < N; i++) begin
            idx = (mptr + i) % N;
            if (el[idx] && (!ev || mcnt[idx] < best)) begin
               ev = 1'b1; tid = idx; best = mcnt[idx];
            end
         end
      end
      sb.push_back('{ev, tid, req});
      #1 ->chk_ev;
      #1;
      for (int t = 0; t < N; t++) begin
         nv = mcnt[t] + ((ev && frdy && tid == t) ? FW : 0)
              - ((t == 0) ? r0 + s0 : r1 + s1);
         if (nv < 0) nv = 0;
         if (nv > MAXC) nv = MAXC;
         mcnt[t] = nv;
      end
      if (ev && frdy) mptr = (tid + 1) % N;
      mhold = ev && !frdy;
      mhtid = tid;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int t = 0; t < N; t++) mcnt[t] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 R2: nothing active after reset -> idle; then pointer at thread 0
      step(2'b00, 2'b11, 1, 0,0,0,0, 0,0, "R2 idle");
      step(2'b11, 2'b11, 0, 0,0,0,0, 0,0, "R1 first grant");
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,0, "R1 accept t0");
      // R3 R5: thread 0 now holds 4, thread 1 wins
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,0, "R3 lower count");
      // R4: tie at 4 each, pointer at 0
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,0, "R4 tie pointer");
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,0, "R4 rotate");
      // R2: thread 1 not ready
      step(2'b11, 2'b01, 1, 0,0,0,0, 0,0, "R2 ready mask");
      step(2'b11, 2'b00, 1, 0,0,0,0, 0,0, "R2 none ready");
      // R6: retire and squash same cycle, clamp at zero
      step(2'b11, 2'b00, 1, 7,3,7,3, 0,0, "R6 drain");
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,0, "R6 after clamp");
      step(2'b11, 2'b11, 1, 2,0,1,0, 0,0, "R6 partial drop");
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,0, "R5 count growth");
      // R7: cap with two active
      step(2'b11, 2'b11, 1, 0,0,0,0, 16,0, "R7 t0 capped");
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,20, "R7 t1 capped");
      step(2'b11, 2'b11, 1, 0,0,0,0, 16,16, "R7 both capped");
      step(2'b11, 2'b11, 1, 0,0,0,0, 15,15, "R7 just under cap");
      // R8: single thread ignores occupancy
      step(2'b01, 2'b11, 1, 0,0,0,0, 32,0, "R8 solo full queue");
      step(2'b10, 2'b11, 1, 0,0,0,0, 0,31, "R8 solo t1");
      // R9: hold while fetch_ready low, counts fall on the other thread
      step(2'b11, 2'b11, 0, 0,0,0,0, 0,0, "R9 stall");
      step(2'b11, 2'b11, 0, 7,7,7,7, 0,0, "R9 held");
      step(2'b11, 2'b11, 0, 0,0,0,0, 0,0, "R9 held again");
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,0, "R9 release");
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,0, "R9 after release");
      // R9: held thread drops eligibility, other thread takes over
      step(2'b11, 2'b11, 0, 0,0,0,0, 0,0, "R9 stall b");
      step(2'b11, 2'b11 ^ 2'(1 << mhtid), 1, 0,0,0,0, 0,0, "R9 held thread gone");
      // R3 R5 R6: longer mixed pattern
      for (int k = 0; k < 40; k++)
         step(2'b11, 2'b11, (k % 3) != 0, k % 2, (k % 5) % 4, (k % 7 == 0) ? 3 : 0, 0,
              (k % 11 == 0) ? 16 : 3, 4, "R3 mixed");
      // R6: upper clamp, thread 0 alone without retire
      for (int k = 0; k < 20; k++)
         step(2'b01, 2'b01, 1, 0,0,0,0, 0,0, "R6 upper clamp");
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,0, "R3 after clamp");
      step(2'b11, 2'b11, 1, 0,0,0,0, 0,0, "R3 after clamp b");
      done = 1'b1;
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule